// File: doc/BRIEF.md
# Overlay Window Shadow Register Bank

This block keeps the placement and enable settings of five overlay windows on a display pipeline. Each window owns a shadow copy, which software writes through a simple register write port, and a live copy, which the rest of the pipeline reads. On a frame-sync strobe every window whose guard bit is clear copies its whole shadow set into its live set in one edge. A window that is being reprogrammed across several writes sets its guard bit first and clears it last. The new placement then takes effect at a single frame boundary, never half-applied.

From the live set the block derives each window's inclusive bottom-right corner, its pixel area (windows 0 to 2 only) and an active flag. It compares the incoming pixel X/Y counters against every live rectangle and raises a per-window hit flag. Blend strength and colour-key value are stored and passed out for windows 1 to 4. Window 0 has neither. The write port is a plain strobe with no back-pressure: every write is taken in the cycle it is presented.

Top module: `ovl_shadow_bank`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every live output and every hit flag is zero. Shadow values and guard bits are also cleared.
- R2: A write changes only the shadow copy. Live outputs keep their value on every edge at which `frame_sync` is low.
- R3: The write address is `{window[2:0], field[2:0]}`. The field codes are:
  - 0 = top-left corner, X in `wr_data[11:0]` and Y in `wr_data[27:16]`.
  - 1 = extent, width in `wr_data[11:0]` and height in `wr_data[27:16]`.
  - 2 = control, bit 0 window enable and bit 1 channel enable.
  - 3 = blend strength `wr_data[11:0]`.
  - 4 = colour key `wr_data[23:0]`.
  - 5 = guard bit `wr_data[0]`.
  
  At an edge with `frame_sync` high and the guard clear, the live set takes the shadow values held before that edge. They appear on the outputs in the next cycle.
- R4: At an edge with `frame_sync` high and the window's guard set, that window's live set is unchanged.
- R5: The live bottom-right corner on each axis is start + extent − 1, or 0 when start + extent is 0. It is CW+1 bits wide so that it never wraps.
- R6: `live_active` is high only when both the window-enable and channel-enable live bits are set.
- R7: `win_hit` of a window is high, in the same cycle as the pixel inputs, exactly when the window is active and the pixel X and Y both lie within its corners, bounds inclusive.
- R8: `live_area` is width × height of the live extent for windows 0 to 2. It is always 0 for windows 3 and 4.
- R9: Window 0's blend and colour-key outputs stay 0 whatever is written to it.
- R10: Writes to window numbers 5 to 7, or to field codes 6 and 7, change no state.
- R11: The guard bit takes effect on the edge of its write, without waiting for a frame sync. The copy at a sync edge is decided by the guard value held before that edge, so a guard write coinciding with a sync does not affect that copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Window number and field code |
| wr_data | input | 32 | Write data |
| frame_sync | input | 1 | One-cycle frame boundary strobe |
| pix_x | input | 12 | Current pixel column |
| pix_y | input | 12 | Current pixel row |
| live_x0 | output | 60 | Live top-left X, 12 bits per window |
| live_y0 | output | 60 | Live top-left Y, 12 bits per window |
| live_x1 | output | 65 | Live bottom-right X, 13 bits per window |
| live_y1 | output | 65 | Live bottom-right Y, 13 bits per window |
| live_active | output | 5 | Window and channel both enabled |
| live_alpha | output | 60 | Live blend strength, 12 bits per window |
| live_key | output | 120 | Live colour key, 24 bits per window |
| live_area | output | 120 | Live width × height, 24 bits per window |
| win_hit | output | 5 | Pixel lies inside an active window |

## Verification
A write is due in the shadow one edge after it is presented, but it becomes visible only through a sync. The live outputs are therefore due exactly one edge after a `frame_sync` cycle. Corners, area and active flag follow in the same cycle from combinational logic, and `win_hit` follows the pixel inputs with no delay. The bench's behavioural model applies sync-copy and write in that order at each rising edge. The model and the design are then compared at the falling edge, after inputs have settled and before new ones are driven. Guard-and-sync collisions, zero extents and writes to absent windows are exercised directly, followed by a random phase.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned FIELD_BITS = 3;

  typedef enum logic [FIELD_BITS-1:0] {
    FLD_CORNER = 3'd0,
    FLD_EXTENT = 3'd1,
    FLD_CTRL   = 3'd2,
    FLD_ALPHA  = 3'd3,
    FLD_KEY    = 3'd4,
    FLD_GUARD  = 3'd5
  } ovl_field_e;
endpackage

// File: rtl/ovl_span_end.sv
module ovl_span_end #(
  parameter int unsigned CW = 12
) (
  input  logic [CW-1:0] start,
  input  logic [CW-1:0] extent,
  output logic [CW:0]   last
);
  logic [CW:0] sum;
  assign sum  = {1'b0, start} + {1'b0, extent};
  assign last = (sum == '0) ? '0 : sum - 1'b1;
endmodule

// File: rtl/ovl_win_slot.sv
module ovl_win_slot
  import ovl_pkg::*;
#(
  parameter int unsigned CW        = 12,
  parameter int unsigned DW        = 32,
  parameter int unsigned ALPHA_W   = 12,
  parameter int unsigned KEY_W     = 24,
  parameter bit          HAS_BLEND = 1'b1,
  parameter bit          HAS_AREA  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  ovl_field_e         fld,
  input  logic [DW-1:0]      wdata,
  input  logic               sync,
  input  logic [CW-1:0]      pix_x,
  input  logic [CW-1:0]      pix_y,
  output logic [CW-1:0]      x0,
  output logic [CW-1:0]      y0,
  output logic [CW:0]        x1,
  output logic [CW:0]        y1,
  output logic               active,
  output logic [ALPHA_W-1:0] alpha,
  output logic [KEY_W-1:0]   key,
  output logic [2*CW-1:0]    area,
  output logic               hit
);
  localparam int unsigned HI = DW / 2;

  logic [CW-1:0] sh_x0, sh_y0, sh_w, sh_h;
  logic [CW-1:0] lv_x0, lv_y0, lv_w, lv_h;
  logic          sh_wen, sh_cen, lv_wen, lv_cen;
  logic          guard;
  logic          copy;
  logic          unused_wdata;

  assign unused_wdata = ^wdata;
  assign copy = sync && !guard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_x0 <= '0; sh_y0 <= '0; sh_w <= '0; sh_h <= '0;
      lv_x0 <= '0; lv_y0 <= '0; lv_w <= '0; lv_h <= '0;
      sh_wen <= 1'b0; sh_cen <= 1'b0; lv_wen <= 1'b0; lv_cen <= 1'b0;
      guard <= 1'b0;
    end else begin
      if (copy) begin
        lv_x0 <= sh_x0; lv_y0 <= sh_y0; lv_w <= sh_w; lv_h <= sh_h;
        lv_wen <= sh_wen; lv_cen <= sh_cen;
      end
      if (sel) begin
        case (fld)
          FLD_CORNER: begin sh_x0 <= wdata[CW-1:0]; sh_y0 <= wdata[HI +: CW]; end
          FLD_EXTENT: begin sh_w  <= wdata[CW-1:0]; sh_h  <= wdata[HI +: CW]; end
          FLD_CTRL:   begin sh_wen <= wdata[0]; sh_cen <= wdata[1]; end
          FLD_GUARD:  guard <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  generate
    if (HAS_BLEND) begin : g_blend
      logic [ALPHA_W-1:0] sh_a, lv_a;
      logic [KEY_W-1:0]   sh_k, lv_k;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sh_a <= '0; lv_a <= '0; sh_k <= '0; lv_k <= '0;
        end else begin
          if (copy) begin lv_a <= sh_a; lv_k <= sh_k; end
          if (sel && fld == FLD_ALPHA) sh_a <= wdata[ALPHA_W-1:0];
          if (sel && fld == FLD_KEY)   sh_k <= wdata[KEY_W-1:0];
        end
      end
      assign alpha = lv_a;
      assign key   = lv_k;
    end else begin : g_noblend
      assign alpha = '0;
      assign key   = '0;
    end

    if (HAS_AREA) begin : g_area
      assign area = {{CW{1'b0}}, lv_w} * {{CW{1'b0}}, lv_h};
    end else begin : g_noarea
      assign area = '0;
    end
  endgenerate

  ovl_span_end #(.CW(CW)) u_end_x (.start(lv_x0), .extent(lv_w), .last(x1));
  ovl_span_end #(.CW(CW)) u_end_y (.start(lv_y0), .extent(lv_h), .last(y1));

  assign x0     = lv_x0;
  assign y0     = lv_y0;
  assign active = lv_wen && lv_cen;
  assign hit    = active
               && ({1'b0, pix_x} >= {1'b0, lv_x0}) && ({1'b0, pix_x} <= x1)
               && ({1'b0, pix_y} >= {1'b0, lv_y0}) && ({1'b0, pix_y} <= y1);

  assert_hold_until_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(x0) && $stable(y0) && $stable(x1) && $stable(y1) && $stable(active));

  assert_copy_on_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && !guard) |=> (lv_x0 == $past(sh_x0)) && (lv_w == $past(sh_w))
                      && (lv_y0 == $past(sh_y0)) && (lv_h == $past(sh_h)));

  assert_guard_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync && guard) |=> $stable(x0) && $stable(y0) && $stable(x1) && $stable(y1));

  assert_corner_inclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (x1 >= {1'b0, x0}) || (lv_w == '0));

  assert_hit_needs_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (lv_wen && lv_cen));
endmodule

// File: rtl/ovl_shadow_bank.sv
module ovl_shadow_bank
  import ovl_pkg::*;
#(
  parameter int unsigned NWIN       = 5,
  parameter int unsigned CW         = 12,
  parameter int unsigned DW         = 32,
  parameter int unsigned ALPHA_W    = 12,
  parameter int unsigned KEY_W      = 24,
  parameter int unsigned AREA_WINS  = 3,
  parameter int unsigned BLEND_FROM = 1,
  localparam int unsigned WB        = $clog2(NWIN),
  localparam int unsigned AW        = WB + FIELD_BITS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    frame_sync,
  input  logic [CW-1:0]           pix_x,
  input  logic [CW-1:0]           pix_y,
  output logic [NWIN*CW-1:0]      live_x0,
  output logic [NWIN*CW-1:0]      live_y0,
  output logic [NWIN*(CW+1)-1:0]  live_x1,
  output logic [NWIN*(CW+1)-1:0]  live_y1,
  output logic [NWIN-1:0]         live_active,
  output logic [NWIN*ALPHA_W-1:0] live_alpha,
  output logic [NWIN*KEY_W-1:0]   live_key,
  output logic [NWIN*2*CW-1:0]    live_area,
  output logic [NWIN-1:0]         win_hit
);
  logic [WB-1:0] wsel;
  ovl_field_e    fld;

  assign wsel = wr_addr[AW-1:FIELD_BITS];
  assign fld  = ovl_field_e'(wr_addr[FIELD_BITS-1:0]);

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      ovl_win_slot #(
        .CW(CW), .DW(DW), .ALPHA_W(ALPHA_W), .KEY_W(KEY_W),
        .HAS_BLEND(w >= BLEND_FROM), .HAS_AREA(w < AREA_WINS)
      ) u_slot (
        .clk(clk), .rst_n(rst_n),
        .sel(wr_en && (wsel == WB'(w))),
        .fld(fld), .wdata(wr_data), .sync(frame_sync),
        .pix_x(pix_x), .pix_y(pix_y),
        .x0(live_x0[w*CW +: CW]), .y0(live_y0[w*CW +: CW]),
        .x1(live_x1[w*(CW+1) +: CW+1]), .y1(live_y1[w*(CW+1) +: CW+1]),
        .active(live_active[w]),
        .alpha(live_alpha[w*ALPHA_W +: ALPHA_W]),
        .key(live_key[w*KEY_W +: KEY_W]),
        .area(live_area[w*2*CW +: 2*CW]),
        .hit(win_hit[w])
      );
    end
  endgenerate

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (win_hit == '0) && (live_active == '0) && (live_x0 == '0) && (live_area == '0));

  assert_w0_no_blend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_alpha[ALPHA_W-1:0] == '0) && (live_key[KEY_W-1:0] == '0));
endmodule

// File: tb/tb_ovl_shadow_bank.sv
module tb_ovl_shadow_bank;
  localparam int NW = 5;
  localparam int CW = 12;

  logic clk = 0, rst_n = 0, wr_en = 0, frame_sync = 0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [CW-1:0] pix_x = '0, pix_y = '0;
  logic [NW*CW-1:0] live_x0, live_y0;
  logic [NW*(CW+1)-1:0] live_x1, live_y1;
  logic [NW-1:0] live_active, win_hit;
  logic [NW*12-1:0] live_alpha;
  logic [NW*24-1:0] live_key;
  logic [NW*24-1:0] live_area;

  ovl_shadow_bank dut (.*);

  always #10 clk = ~clk;

  int vectors = 0, miscompares = 0;
  string phase = "R1";
  bit done = 0;

  int sx0[NW], sy0[NW], sw[NW], sh[NW], swe[NW], sce[NW], sa[NW], sk[NW];
  int lx0[NW], ly0[NW], lw[NW], lh[NW], lwe[NW], lce[NW], la[NW], lk[NW];
  int gd[NW];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NW; w++) begin
        sx0[w]=0; sy0[w]=0; sw[w]=0; sh[w]=0; swe[w]=0; sce[w]=0; sa[w]=0; sk[w]=0;
        lx0[w]=0; ly0[w]=0; lw[w]=0; lh[w]=0; lwe[w]=0; lce[w]=0; la[w]=0; lk[w]=0; gd[w]=0;
      end
    end else begin
      if (frame_sync)
        for (int w = 0; w < NW; w++)
          if (gd[w] == 0) begin
            lx0[w]=sx0[w]; ly0[w]=sy0[w]; lw[w]=sw[w]; lh[w]=sh[w];
            lwe[w]=swe[w]; lce[w]=sce[w]; la[w]=sa[w]; lk[w]=sk[w];
          end
      if (wr_en && wr_addr[5:3] < NW) begin
        automatic int w = wr_addr[5:3];
        case (wr_addr[2:0])
          0: begin sx0[w] = wr_data[11:0]; sy0[w] = wr_data[27:16]; end
          1: begin sw[w]  = wr_data[11:0]; sh[w]  = wr_data[27:16]; end
          2: begin swe[w] = wr_data[0]; sce[w] = wr_data[1]; end
          3: sa[w] = wr_data[11:0];
          4: sk[w] = wr_data[23:0];
          5: gd[w] = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  function automatic int last_of(int s, int e);
    return (s + e == 0) ? 0 : s + e - 1;
  endfunction

  task automatic chk(string tag, string what, int w, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s win%0d got %0h expected %0h (phase %s)", tag, what, w, got, exp, phase);
    end
  endtask

  task automatic compare();
    for (int w = 0; w < NW; w++) begin
      automatic int x1 = last_of(lx0[w], lw[w]);
      automatic int y1 = last_of(ly0[w], lh[w]);
      automatic int act = lwe[w] & lce[w];
      automatic int h = act && pix_x >= lx0[w] && pix_x <= x1 && pix_y >= ly0[w] && pix_y <= y1;
      chk("R3", "x0", w, live_x0[w*CW +: CW], lx0[w]);
      chk("R3", "y0", w, live_y0[w*CW +: CW], ly0[w]);
      chk("R5", "x1", w, live_x1[w*(CW+1) +: CW+1], x1);
      chk("R5", "y1", w, live_y1[w*(CW+1) +: CW+1], y1);
      chk("R6", "active", w, live_active[w], act);
      chk("R9", "alpha", w, live_alpha[w*12 +: 12], (w == 0) ? 0 : la[w]);
      chk("R9", "key", w, live_key[w*24 +: 24], (w == 0) ? 0 : lk[w]);
      chk("R8", "area", w, live_area[w*24 +: 24], (w < 3) ? lw[w] * lh[w] : 0);
      chk("R7", "hit", w, win_hit[w], h);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); compare();
  endtask

  task automatic wr(int w, int f, logic [31:0] d);
    wr_en = 1; wr_addr = {w[2:0], f[2:0]}; wr_data = d; tick(); wr_en = 0;
  endtask

  task automatic sync();
    frame_sync = 1; tick(); frame_sync = 0;
  endtask

  task automatic pix(int x, int y);
    pix_x = x[CW-1:0]; pix_y = y[CW-1:0]; tick();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    phase = "R1";
    repeat (3) tick();
    rst_n = 1; tick();

    phase = "R2"; // shadow writes leave live untouched
    wr(1, 0, {4'h0, 12'd20, 4'h0, 12'd10});
    wr(1, 1, {4'h0, 12'd4, 4'h0, 12'd5});
    wr(1, 2, 32'h3);
    wr(1, 3, 32'h0abc);
    pix(10, 20);

    phase = "R3";
    sync();
    phase = "R7"; // inclusive bounds: 10..14 by 20..23
    pix(10, 20); pix(14, 23); pix(15, 23); pix(9, 20); pix(14, 24); pix(12, 19);

    phase = "R6";
    wr(1, 2, 32'h1); sync(); pix(12, 21);
    wr(1, 2, 32'h2); sync(); pix(12, 21);
    wr(1, 2, 32'h3); sync(); pix(12, 21);

    phase = "R4";
    wr(2, 5, 32'h1);
    wr(2, 0, {4'h0, 12'd100, 4'h0, 12'd50});
    wr(2, 1, {4'h0, 12'd8, 4'h0, 12'd8});
    wr(2, 2, 32'h3);
    sync(); pix(52, 102); sync();

    phase = "R11";
    wr(2, 5, 32'h0); pix(52, 102); sync(); pix(52, 102);
    // guard set in the same cycle as a sync: that copy still happens
    wr(2, 1, {4'h0, 12'd2, 4'h0, 12'd2});
    wr_en = 1; wr_addr = {3'd2, 3'd5}; wr_data = 32'h1; frame_sync = 1; tick();
    wr_en = 0; frame_sync = 0;
    wr(2, 1, {4'h0, 12'd9, 4'h0, 12'd9}); sync(); pix(51, 101);
    wr(2, 5, 32'h0); sync();

    phase = "R9";
    wr(0, 3, 32'hfff); wr(0, 4, 32'hffffff); wr(0, 2, 32'h3);
    wr(0, 1, {4'h0, 12'd3, 4'h0, 12'd7}); sync();

    phase = "R8";
    wr(3, 1, {4'h0, 12'd30, 4'h0, 12'd40}); wr(4, 1, {4'h0, 12'hfff, 4'h0, 12'hfff});
    wr(2, 1, {4'h0, 12'hfff, 4'h0, 12'hfff}); sync();

    phase = "R5"; // zero extent at zero offset clamps to 0; wide sums do not wrap
    wr(3, 0, 32'h0); wr(3, 1, 32'h0); wr(3, 2, 32'h3);
    wr(4, 0, {4'h0, 12'hffe, 4'h0, 12'hffe}); wr(4, 2, 32'h3); sync();
    pix(0, 0); pix(4094, 4094); pix(4095, 4095);

    phase = "R10";
    wr(5, 0, 32'h00100010); wr(7, 1, 32'h00100010); wr(1, 6, 32'hffffffff);
    wr(1, 7, 32'hffffffff); sync(); pix(12, 21);

    phase = "R3";
    for (int i = 0; i < 2000; i++) begin
      wr_en = ($urandom_range(0, 2) != 0);
      wr_addr = $urandom_range(0, 63);
      wr_data = $urandom();
      if (wr_addr[2:0] == 3'd5 && $urandom_range(0, 1) == 1) wr_data[0] = 1'b0;
      frame_sync = ($urandom_range(0, 7) == 0);
      pix_x = $urandom_range(0, 4095);
      pix_y = $urandom_range(0, 4095);
      tick();
    end
    wr_en = 0; frame_sync = 0;
    phase = "R1";
    rst_n = 0; tick(); tick();

    done = 1;
    finish_run();
  end
endmodule